// File: doc/BRIEF.md
# Descriptor Ring Copy Queue Engine

This block runs one DMA queue. Its work list is a ring of descriptors in memory. Software builds each descriptor in the ring slot just after the last one it posted. It then writes the new producer index to a doorbell register. The engine reads descriptors one after another, starting at its own consumer index. For each one it copies the described number of 32-bit words from a source address to a destination address. Once the last word of that descriptor has been written, it steps the consumer index forward by one.

Software can move the producer index forward at any time, including while a copy is running. The engine picks up the new work when it finishes the current descriptor. It needs no restart and no tail pointer. The engine goes idle exactly when its consumer index has caught up with the producer index.

The engine has three memory ports, each using a valid/ready handshake with one word per beat: a read request port, a read response port whose data comes back in request order after a variable delay, and a write port. The register port has a write strobe and a read path that follows the address combinationally.

Top module: `ring_dma_engine`

## Requirements
- R1: After reset, every register reads back as follows: ring base 0, ring size code 2, producer index 0, consumer index 0, control/status 0. Register offsets are 0x00 base, 0x04 size code (log2 of the entry count), 0x08 producer index, 0x0C consumer index (read only), 0x10 control/status. Control/status bits are: bit 0 enable, bit 1 busy, bit 2 overflow error, bit 3 descriptor error.
- R2: Descriptor i sits at base + 16*i. Its four words, in address order, are source address, destination address, byte length and control. Descriptors are executed strictly in ring order.
- R3: A descriptor with byte length L copies L/4 words. Word k is read from source + 4k and written to destination + 4k. No other address is written. The consumer index advances by one only after the last write of the descriptor has been accepted.
- R4: While the consumer index equals the producer index, busy reads 0 and no read or write request is issued.
- R5: A producer index written while a descriptor is being copied is taken up after that descriptor finishes, without any other register access.
- R6: A doorbell write is refused when (new index − producer index) + (producer index − consumer index), each taken modulo the ring size, would exceed ring size − 1. A refused write leaves the producer index unchanged and sets bit 2. A write that exactly reaches ring size − 1 is accepted.
- R7: A descriptor with byte length 0 causes no copy traffic, and it still advances the consumer index.
- R8: A descriptor whose control word has bit 0 clear sets bit 3 and halts the engine without advancing the consumer index. Writing 1 to bit 3 clears the flag, and the engine then fetches the same descriptor again.
- R9: Clearing enable while a descriptor is in progress lets that descriptor complete. No further descriptor is then fetched.
- R10: Bits 2 and 3 are cleared only by writing 1 to them. Writing 0 leaves them unchanged.
- R11: At most one read is outstanding. No read request is presented until the previous read's data has returned.
- R12: A size code written outside 2..8 is clamped into that range. The producer and consumer indexes wrap modulo 2^code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, follows reg_addr |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data word |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data word |

## Verification
A doorbell write can land in the same cycle in which the engine advances its consumer index. In that cycle the room check sees the old consumer index, and the index update is also in flight. To provoke this, the bench posts single descriptors at delays swept from 0 to 11 cycles after the previous doorbell. Random ready and read-response latencies move the completion cycles around, and the run wraps the ring several times. The result is judged at the end: the final consumer index must equal the posted count modulo the ring size, every destination buffer must match the arithmetic source pattern, and the total number of write beats must equal the sum of the posted lengths.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;

    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 4;
    localparam int DESC_BYTES_LOG2 = 4;

    // control/status bit positions
    localparam int CS_EN   = 0;
    localparam int CS_BUSY = 1;
    localparam int CS_OVF  = 2;
    localparam int CS_DERR = 3;

    typedef enum logic [2:0] {
        SEL_BASE = 3'd0,
        SEL_LOG2 = 3'd1,
        SEL_PIDX = 3'd2,
        SEL_CIDX = 3'd3,
        SEL_CTRL = 3'd4
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_REQ,
        ST_FETCH_RSP,
        ST_COPY_REQ,
        ST_COPY_RSP,
        ST_COPY_WR,
        ST_RETIRE,
        ST_HALT
    } eng_state_e;

    // word 0 at the least significant end
    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] len;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] src;
    } desc_t;

    function automatic logic [ADDR_W-1:0] slot_word_addr(
        input logic [ADDR_W-1:0] base,
        input logic [ADDR_W-1:0] idx,
        input logic [1:0]        word
    );
        return base + (idx << DESC_BYTES_LOG2) + {{(ADDR_W-4){1'b0}}, word, 2'b00};
    endfunction

endpackage

// File: rtl/ring_dma_regs.sv
module ring_dma_regs
    import ring_dma_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int MIN_LOG2 = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [4:0]         reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    input  logic [IDX_W-1:0]   cidx_i,
    input  logic               busy_i,
    input  logic               derr_set_i,
    output logic [ADDR_W-1:0]  base_o,
    output logic [IDX_W-1:0]   mask_o,
    output logic [IDX_W-1:0]   pidx_o,
    output logic               enable_o,
    output logic               derr_o
);

    localparam int LOG2_W = $clog2(IDX_W + 1);

    logic [ADDR_W-1:0] base_q;
    logic [LOG2_W-1:0] log2_q;
    logic [IDX_W-1:0]  pidx_q;
    logic              en_q;
    logic              ovf_q;
    logic              derr_q;

    reg_sel_e          sel;
    logic [IDX_W-1:0]  mask_w;
    logic [IDX_W-1:0]  pending;
    logic [IDX_W-1:0]  advance;
    logic [IDX_W:0]    room_sum;
    logic              db_wr;
    logic              ovf_hit;
    logic              ctrl_wr;

    assign sel = reg_sel_e'(reg_addr[4:2]);

    for (genvar gi = 0; gi < IDX_W; gi++) begin : g_mask
        assign mask_w[gi] = (LOG2_W'(gi) < log2_q);
    end

    assign db_wr    = reg_we && (sel == SEL_PIDX);
    assign ctrl_wr  = reg_we && (sel == SEL_CTRL);
    assign pending  = (pidx_q - cidx_i) & mask_w;
    assign advance  = (reg_wdata[IDX_W-1:0] - pidx_q) & mask_w;
    assign room_sum = {1'b0, advance} + {1'b0, pending};
    assign ovf_hit  = db_wr && (room_sum > {1'b0, mask_w});

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            log2_q <= LOG2_W'(MIN_LOG2);
            pidx_q <= '0;
            en_q   <= 1'b0;
            ovf_q  <= 1'b0;
            derr_q <= 1'b0;
        end else begin
            if (reg_we && sel == SEL_BASE) begin
                base_q <= reg_wdata;
            end
            if (reg_we && sel == SEL_LOG2) begin
                if (reg_wdata < WORD_W'(MIN_LOG2)) begin
                    log2_q <= LOG2_W'(MIN_LOG2);
                end else if (reg_wdata > WORD_W'(IDX_W)) begin
                    log2_q <= LOG2_W'(IDX_W);
                end else begin
                    log2_q <= reg_wdata[LOG2_W-1:0];
                end
            end
            if (db_wr && !ovf_hit) begin
                pidx_q <= reg_wdata[IDX_W-1:0] & mask_w;
            end
            if (ctrl_wr) begin
                en_q <= reg_wdata[CS_EN];
            end
            if (ovf_hit) begin
                ovf_q <= 1'b1;
            end else if (ctrl_wr && reg_wdata[CS_OVF]) begin
                ovf_q <= 1'b0;
            end
            if (derr_set_i) begin
                derr_q <= 1'b1;
            end else if (ctrl_wr && reg_wdata[CS_DERR]) begin
                derr_q <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_BASE: reg_rdata = base_q;
            SEL_LOG2: reg_rdata = WORD_W'(log2_q);
            SEL_PIDX: reg_rdata = WORD_W'(pidx_q);
            SEL_CIDX: reg_rdata = WORD_W'(cidx_i);
            SEL_CTRL: begin
                reg_rdata[CS_EN]   = en_q;
                reg_rdata[CS_BUSY] = busy_i;
                reg_rdata[CS_OVF]  = ovf_q;
                reg_rdata[CS_DERR] = derr_q;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign base_o   = base_q;
    assign mask_o   = mask_w;
    assign pidx_o   = pidx_q;
    assign enable_o = en_q;
    assign derr_o   = derr_q;

    // R6: a refused doorbell leaves the producer index alone and raises the flag
    a_r6_refused_doorbell: assert property (@(posedge clk) disable iff (rst)
        ovf_hit |=> ($stable(pidx_q) && ovf_q));

    // R10: writing zero to a set error bit keeps it
    a_r10_w1c_keep_derr: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !reg_wdata[CS_DERR] && derr_q) |=> derr_q);

    a_r10_w1c_keep_ovf: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !reg_wdata[CS_OVF] && ovf_q) |=> ovf_q);

endmodule

// File: rtl/ring_dma_core.sv
module ring_dma_core
    import ring_dma_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [IDX_W-1:0]   mask_i,
    input  logic [IDX_W-1:0]   pidx_i,
    input  logic               enable_i,
    input  logic               derr_i,
    output logic [IDX_W-1:0]   cidx_o,
    output logic               busy_o,
    output logic               derr_set_o,
    output logic               rd_req_valid_o,
    input  logic               rd_req_ready_i,
    output logic [ADDR_W-1:0]  rd_req_addr_o,
    input  logic               rd_rsp_valid_i,
    input  logic [WORD_W-1:0]  rd_rsp_data_i,
    output logic               wr_valid_o,
    input  logic               wr_ready_i,
    output logic [ADDR_W-1:0]  wr_addr_o,
    output logic [WORD_W-1:0]  wr_data_o
);

    localparam int CNT_W = WORD_W - 2;

    eng_state_e                          state_q;
    logic [1:0]                          widx_q;
    logic [DESC_WORDS-1:0][WORD_W-1:0]   words_q;
    logic [CNT_W-1:0]                    left_q;
    logic [ADDR_W-1:0]                   off_q;
    logic [WORD_W-1:0]                   data_q;
    logic [IDX_W-1:0]                    cidx_q;
    desc_t                               desc;
    logic [CNT_W-1:0]                    len_words;
    logic                                rd_out_q;

    assign desc      = desc_t'(words_q);
    assign len_words = desc.len[WORD_W-1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            widx_q  <= '0;
            words_q <= '0;
            left_q  <= '0;
            off_q   <= '0;
            data_q  <= '0;
            cidx_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (enable_i && !derr_i && (cidx_q != pidx_i)) begin
                        widx_q  <= '0;
                        state_q <= ST_FETCH_REQ;
                    end
                end
                ST_FETCH_REQ: begin
                    if (rd_req_ready_i) begin
                        state_q <= ST_FETCH_RSP;
                    end
                end
                ST_FETCH_RSP: begin
                    if (rd_rsp_valid_i) begin
                        words_q[widx_q] <= rd_rsp_data_i;
                        if (widx_q == 2'd3) begin
                            off_q  <= '0;
                            left_q <= len_words;
                            if (!rd_rsp_data_i[0]) begin
                                state_q <= ST_HALT;
                            end else if (len_words == '0) begin
                                state_q <= ST_RETIRE;
                            end else begin
                                state_q <= ST_COPY_REQ;
                            end
                        end else begin
                            widx_q  <= widx_q + 2'd1;
                            state_q <= ST_FETCH_REQ;
                        end
                    end
                end
                ST_COPY_REQ: begin
                    if (rd_req_ready_i) begin
                        state_q <= ST_COPY_RSP;
                    end
                end
                ST_COPY_RSP: begin
                    if (rd_rsp_valid_i) begin
                        data_q  <= rd_rsp_data_i;
                        state_q <= ST_COPY_WR;
                    end
                end
                ST_COPY_WR: begin
                    if (wr_ready_i) begin
                        if (left_q == CNT_W'(1)) begin
                            state_q <= ST_RETIRE;
                        end else begin
                            left_q  <= left_q - CNT_W'(1);
                            off_q   <= off_q + ADDR_W'(4);
                            state_q <= ST_COPY_REQ;
                        end
                    end
                end
                ST_RETIRE: begin
                    cidx_q  <= (cidx_q + IDX_W'(1)) & mask_i;
                    state_q <= ST_IDLE;
                end
                ST_HALT: begin
                    if (!derr_i) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_req_valid_o = (state_q == ST_FETCH_REQ) || (state_q == ST_COPY_REQ);
        if (state_q == ST_FETCH_REQ) begin
            rd_req_addr_o = slot_word_addr(base_i, ADDR_W'(cidx_q), widx_q);
        end else begin
            rd_req_addr_o = desc.src + off_q;
        end
    end

    assign wr_valid_o = (state_q == ST_COPY_WR);
    assign wr_addr_o  = desc.dst + off_q;
    assign wr_data_o  = data_q;
    assign busy_o     = (state_q != ST_IDLE) && (state_q != ST_HALT);
    assign derr_set_o = (state_q == ST_FETCH_RSP) && rd_rsp_valid_i &&
                        (widx_q == 2'd3) && !rd_rsp_data_i[0];
    assign cidx_o     = cidx_q;

    // independent outstanding-read tracker for the checks below
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_out_q <= 1'b0;
        end else if (rd_req_valid_o && rd_req_ready_i) begin
            rd_out_q <= 1'b1;
        end else if (rd_rsp_valid_i) begin
            rd_out_q <= 1'b0;
        end
    end

    // R11: no read request while one is still in flight
    a_r11_single_read: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid_o |-> !rd_out_q);

    // R3 / R12: consumer index only ever steps by one within the ring
    a_r3_cidx_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(cidx_q) |-> (cidx_q == (($past(cidx_q) + IDX_W'(1)) & $past(mask_i))));

    // R4: caught up and idle means a quiet memory interface
    a_r4_quiet_when_empty: assert property (@(posedge clk) disable iff (rst)
        ((cidx_q == pidx_i) && !busy_o) |-> (!rd_req_valid_o && !wr_valid_o));

    // R8: a set descriptor error holds off all memory traffic
    a_r8_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        derr_i |-> (!rd_req_valid_o && !wr_valid_o));

    // R9: disabled and idle stays idle
    a_r9_disabled_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (!enable_i && !busy_o) |=> !busy_o);

    // R2: read request held steady until accepted
    a_r2_rd_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_req_valid_o && !rd_req_ready_i) |=> (rd_req_valid_o && $stable(rd_req_addr_o)));

    a_r3_wr_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

endmodule

// File: rtl/ring_dma_engine.sv
module ring_dma_engine
    import ring_dma_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int MIN_LOG2 = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        rd_req_valid,
    input  logic        rd_req_ready,
    output logic [31:0] rd_req_addr,
    input  logic        rd_rsp_valid,
    input  logic [31:0] rd_rsp_data,
    output logic        wr_valid,
    input  logic        wr_ready,
    output logic [31:0] wr_addr,
    output logic [31:0] wr_data
);

    logic [ADDR_W-1:0] base_w;
    logic [IDX_W-1:0]  mask_w;
    logic [IDX_W-1:0]  pidx_w;
    logic [IDX_W-1:0]  cidx_w;
    logic              enable_w;
    logic              derr_w;
    logic              busy_w;
    logic              derr_set_w;

    ring_dma_regs #(
        .IDX_W    (IDX_W),
        .MIN_LOG2 (MIN_LOG2)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .cidx_i     (cidx_w),
        .busy_i     (busy_w),
        .derr_set_i (derr_set_w),
        .base_o     (base_w),
        .mask_o     (mask_w),
        .pidx_o     (pidx_w),
        .enable_o   (enable_w),
        .derr_o     (derr_w)
    );

    ring_dma_core #(
        .IDX_W (IDX_W)
    ) u_core (
        .clk            (clk),
        .rst            (rst),
        .base_i         (base_w),
        .mask_i         (mask_w),
        .pidx_i         (pidx_w),
        .enable_i       (enable_w),
        .derr_i         (derr_w),
        .cidx_o         (cidx_w),
        .busy_o         (busy_w),
        .derr_set_o     (derr_set_w),
        .rd_req_valid_o (rd_req_valid),
        .rd_req_ready_i (rd_req_ready),
        .rd_req_addr_o  (rd_req_addr),
        .rd_rsp_valid_i (rd_rsp_valid),
        .rd_rsp_data_i  (rd_rsp_data),
        .wr_valid_o     (wr_valid),
        .wr_ready_i     (wr_ready),
        .wr_addr_o      (wr_addr),
        .wr_data_o      (wr_data)
    );

endmodule

// File: tb/ring_dma_engine_bench.sv
module ring_dma_engine_bench;

    localparam int MEM_WORDS = 8192;
    localparam logic [31:0] RING_BASE = 32'h0000_1000;
    localparam logic [4:0] A_BASE = 5'h00, A_LOG2 = 5'h04, A_PIDX = 5'h08,
                           A_CIDX = 5'h0C, A_CTRL = 5'h10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b0;
    logic [31:0] rd_req_addr;
    logic        rd_rsp_valid = 1'b0;
    logic [31:0] rd_rsp_data = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;

    // host write path into the memory model
    logic        hw_en = 1'b0;
    logic [31:0] hw_addr = '0;
    logic [31:0] hw_data = '0;

    logic [31:0] mem [0:MEM_WORDS-1];
    logic [15:0] lfsr;
    logic        pend;
    logic [31:0] pend_addr;
    logic [2:0]  lat;
    int          wr_cnt;
    int          rd_cnt;
    int          r11_viol;
    int          cyc = 0;
    int          checks = 0;
    int          fails = 0;
    int          desc_words [0:63];
    int          desc_used  [0:63];
    int          expect_wr = 0;

    always #2 clk = ~clk;

    ring_dma_engine u_ring_dma_engine (
        .clk          (clk),
        .rst          (rst),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .rd_req_valid (rd_req_valid),
        .rd_req_ready (rd_req_ready),
        .rd_req_addr  (rd_req_addr),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_data  (rd_rsp_data),
        .wr_valid     (wr_valid),
        .wr_ready     (wr_ready),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, a[15:0]};
    endfunction

    function automatic logic [31:0] src_of(input int n);
        return 32'h0000_2000 + 32'((n % 8) * 32'h40);
    endfunction

    function automatic logic [31:0] dst_of(input int n);
        return 32'h0000_4000 + 32'(n * 32'h80);
    endfunction

    // memory model with random handshakes and 1..4 cycle read latency
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            lfsr         <= 16'hACE1;
            pend         <= 1'b0;
            pend_addr    <= '0;
            lat          <= '0;
            rd_rsp_valid <= 1'b0;
            rd_req_ready <= 1'b0;
            wr_ready     <= 1'b0;
            wr_cnt       <= 0;
            rd_cnt       <= 0;
            r11_viol     <= 0;
            for (int i = 0; i < MEM_WORDS; i++) begin
                mem[i] <= (i >= 2048 && i < 2176) ? pat(32'(i * 4)) : 32'h0;
            end
        end else begin
            lfsr         <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rd_req_ready <= lfsr[0] | lfsr[3];
            wr_ready     <= lfsr[1] | lfsr[5];
            rd_rsp_valid <= 1'b0;
            if (rd_req_valid && rd_req_ready) begin
                if (pend) r11_viol <= r11_viol + 1;
                pend      <= 1'b1;
                pend_addr <= rd_req_addr;
                lat       <= {1'b0, lfsr[2:1]};
                rd_cnt    <= rd_cnt + 1;
            end else if (pend) begin
                if (lat == 0) begin
                    rd_rsp_valid <= 1'b1;
                    rd_rsp_data  <= mem[pend_addr[14:2]];
                    pend         <= 1'b0;
                end else begin
                    lat <= lat - 3'd1;
                end
            end
            if (wr_valid && wr_ready) begin
                mem[wr_addr[14:2]] <= wr_data;
                wr_cnt <= wr_cnt + 1;
            end
            if (hw_en) mem[hw_addr[14:2]] <= hw_data;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic host_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        hw_en = 1'b1; hw_addr = a; hw_data = d;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    task automatic post(input int n, input int words, input logic [31:0] ctl);
        logic [31:0] slot;
        slot = RING_BASE + 32'((n % 8) * 16);
        host_write(slot,       src_of(n));
        host_write(slot + 4,   dst_of(n));
        host_write(slot + 8,   32'(words * 4));
        host_write(slot + 12,  ctl);
        desc_words[n] = words;
        desc_used[n]  = 1;
    endtask

    task automatic wait_idle(input int target, output bit ok);
        logic [31:0] c, s;
        ok = 1'b0;
        for (int t = 0; t < 3000; t++) begin
            reg_read(A_CIDX, c);
            reg_read(A_CTRL, s);
            if (c == 32'(target) && !s[1]) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic check_data(input int n, input string req);
        bit ok = 1'b1;
        logic [31:0] act = '0, exp = '0;
        for (int j = 0; j < desc_words[n]; j++) begin
            if (mem[(dst_of(n) >> 2) + 32'(j)] !== pat(src_of(n) + 32'(4 * j)) && ok) begin
                ok  = 1'b0;
                act = mem[(dst_of(n) >> 2) + 32'(j)];
                exp = pat(src_of(n) + 32'(4 * j));
            end
        end
        if (mem[(dst_of(n) >> 2) + 32'(desc_words[n])] !== 32'h0 && ok) begin
            ok  = 1'b0;
            act = mem[(dst_of(n) >> 2) + 32'(desc_words[n])];
            exp = 32'h0;
        end
        chk(ok, req, act, exp);
    endtask

    always @(posedge clk) begin
        if (cyc == 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c0, w0;
        bit ok;
        int n;
        for (int i = 0; i < 64; i++) begin desc_words[i] = 0; desc_used[i] = 0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        reg_read(A_BASE, v); chk(v == 0, "R1 base", v, 0);
        reg_read(A_LOG2, v); chk(v == 2, "R1 size code", v, 2);
        reg_read(A_PIDX, v); chk(v == 0, "R1 pidx", v, 0);
        reg_read(A_CIDX, v); chk(v == 0, "R1 cidx", v, 0);
        reg_read(A_CTRL, v); chk(v == 0, "R1 ctrl", v, 0);

        // R12 clamping of size code
        reg_write(A_LOG2, 32'd20); reg_read(A_LOG2, v); chk(v == 8, "R12 clamp high", v, 8);
        reg_write(A_LOG2, 32'd1);  reg_read(A_LOG2, v); chk(v == 2, "R12 clamp low", v, 2);
        reg_write(A_LOG2, 32'd3);  reg_read(A_LOG2, v); chk(v == 3, "R12 in range", v, 3);
        reg_write(A_BASE, RING_BASE);
        reg_write(A_CTRL, 32'h1);

        // R2 / R3 first batch of three
        n = 0;
        post(0, 1, 1); post(1, 3, 1); post(2, 4, 1);
        expect_wr = 8;
        reg_write(A_PIDX, 32'd3);
        wait_idle(3, ok); chk(ok, "R2 batch drained", 32'(ok), 1);
        for (int k = 0; k < 3; k++) check_data(k, "R3 batch data");
        chk(wr_cnt == expect_wr, "R3 write beats", 32'(wr_cnt), 32'(expect_wr));
        n = 3;

        // R4 quiet while caught up
        c0 = 32'(rd_cnt); w0 = 32'(wr_cnt);
        repeat (50) @(negedge clk);
        chk(rd_cnt == int'(c0) && wr_cnt == int'(w0), "R4 quiet idle", 32'(rd_cnt), c0);

        // R5 / R12 doorbell sweep, wraps ring
        for (int d = 0; d < 12; d++) begin
            v = 32'd7;
            while (v >= 7) begin
                reg_read(A_CIDX, c0);
                v = (32'(n) - c0) & 32'h7;
            end
            post(n, 1 + (n % 4), 1);
            expect_wr += 1 + (n % 4);
            n++;
            reg_write(A_PIDX, 32'(n % 8));
            repeat (d) @(negedge clk);
        end
        wait_idle(n % 8, ok); chk(ok, "R5 sweep drained", 32'(ok), 1);
        reg_read(A_CIDX, v); chk(v == 32'(n % 8), "R12 cidx wrap", v, 32'(n % 8));
        for (int k = 3; k < n; k++) check_data(k, "R5 sweep data");
        chk(wr_cnt == expect_wr, "R5 write beats", 32'(wr_cnt), 32'(expect_wr));

        // R7 zero length
        post(n, 0, 1);
        n++;
        reg_write(A_PIDX, 32'(n % 8));
        wait_idle(n % 8, ok); chk(ok, "R7 skip retires", 32'(ok), 1);
        chk(wr_cnt == expect_wr, "R7 no writes", 32'(wr_cnt), 32'(expect_wr));
        check_data(n - 1, "R7 dst untouched");

        // R8 invalid descriptor halts, then retried
        post(n, 2, 0);
        reg_write(A_PIDX, 32'((n + 1) % 8));
        repeat (80) @(negedge clk);
        reg_read(A_CTRL, v); chk(v[3] && !v[1], "R8 halt flag", v, 32'h9);
        reg_read(A_CIDX, v); chk(v == 32'(n % 8), "R8 cidx held", v, 32'(n % 8));
        chk(wr_cnt == expect_wr, "R8 no copy", 32'(wr_cnt), 32'(expect_wr));
        reg_write(A_CTRL, 32'h1);
        reg_read(A_CTRL, v); chk(v[3], "R10 derr kept on zero write", v, 32'h9);
        host_write(RING_BASE + 32'((n % 8) * 16) + 12, 32'h1);
        reg_write(A_CTRL, 32'h9);
        expect_wr += 2;
        n++;
        wait_idle(n % 8, ok); chk(ok, "R8 retried", 32'(ok), 1);
        check_data(n - 1, "R8 retried data");

        // R9 disable mid descriptor
        post(n, 4, 1); post(n + 1, 4, 1);
        reg_write(A_PIDX, 32'((n + 2) % 8));
        v = 0;
        while (!v[1]) reg_read(A_CTRL, v);
        reg_write(A_CTRL, 32'h0);
        expect_wr += 4;
        n++;
        wait_idle(n % 8, ok); chk(ok, "R9 current done", 32'(ok), 1);
        c0 = 32'(rd_cnt);
        repeat (100) @(negedge clk);
        reg_read(A_CIDX, v); chk(v == 32'(n % 8), "R9 no next fetch", v, 32'(n % 8));
        chk(rd_cnt == int'(c0) && wr_cnt == expect_wr, "R9 quiet", 32'(rd_cnt), c0);
        check_data(n - 1, "R9 data");

        // R6 overflow boundary (one pending)
        reg_write(A_PIDX, 32'((n + 7) % 8));
        reg_read(A_PIDX, v); chk(v == 32'((n + 7) % 8), "R6 full accepted", v, 32'((n + 7) % 8));
        reg_read(A_CTRL, v); chk(!v[2], "R6 no flag at limit", v, 0);
        reg_write(A_PIDX, 32'(n % 8));
        reg_read(A_PIDX, v); chk(v == 32'((n + 7) % 8), "R6 refused pidx", v, 32'((n + 7) % 8));
        reg_read(A_CTRL, v); chk(v[2], "R6 flag set", v, 32'h4);
        reg_write(A_CTRL, 32'h0);
        reg_read(A_CTRL, v); chk(v[2], "R10 ovf kept", v, 32'h4);
        reg_write(A_CTRL, 32'h4);
        reg_read(A_CTRL, v); chk(!v[2], "R10 ovf cleared", v, 0);

        chk(r11_viol == 0, "R11 single read", 32'(r11_viol), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule